// File: doc/BRIEF.md
# Parallel EPROM Programming Pulse Sequencer

This block sits on the programmer side of a parallel-mode EPROM programming setup for an 8-bit microcontroller. A host hands it one operation at a time: an operation code, a 14-bit target address and a data byte. For write operations (the code array, an encryption-table entry, or one of three lock bits), the block puts the address, data and mode straps on the target pins. After a setup window it enables the programming supply and emits a train of active-low PROG pulses. It then drops the supply and holds the pins for a while before it reports completion.

For read operations (code verify and signature read) the supply stays off, PROG stays high and the data bus is released. The block waits a fixed number of reference clocks and then returns the byte the target drives. All windows are counted in reference clocks or in microseconds. A prescaler of parameterised ratio derives the microsecond unit from the clock. Analog supply generation is outside the block; it only drives an enable.

Top module: `eprom_pulse_seq`

## Requirements
- R1: After reset, and whenever no operation is in flight, `ready_o`=1, `done_o`=0, `vpp_en_o`=0, `prog_n_o`=1, `bus_oe_o`=0, `psen_n_o`=1, `tgt_rst_o`=1 and the address, strap and data outputs are zero.
- R2: While busy, the outputs hold these values. `addr_lo_o` carries address bits 7:0 and `addr_hi_o` carries bits 13:8. `tgt_rst_o`=1 and `psen_n_o`=0. `bus_oe_o`=1 with `bus_o` equal to the data byte for write operations only. `straps_o` is {P3.7,P3.6,P3.3,P2.7,P2.6} = code write 11110, verify 11000, encryption write 10110, lock 1 11111, lock 2 00111, lock 3 01101, signature 00000. All of these stay constant for the whole operation.
- R3: Operation codes are 0 code write, 1 verify, 2 encryption write, 3/4/5 lock bit 1/2/3, 6 signature read. A start with code 7 is ignored, and a start while busy has no effect on the operation in progress.
- R4: For writes, the pins are applied for exactly SETUP_CLKS clocks with `vpp_en_o`=0. `vpp_en_o` then rises, and the first PROG fall comes exactly LEAD_US microseconds later. PROG is never low while `vpp_en_o` is 0.
- R5: A code write emits CODE_PULSES PROG pulses; encryption and lock writes emit SPECIAL_PULSES pulses.
- R6: Each PROG low pulse lasts exactly PULSE_US microseconds, and PROG stays high exactly GAP_US microseconds between pulses.
- R7: `vpp_en_o` stays high exactly TAIL_US microseconds after the last PROG rise. The pins then stay held for HOLD_CLKS clocks before completion.
- R8: Reads never raise `vpp_en_o` or lower PROG. `done_o` is asserted READ_CLKS+SETUP_CLKS clocks after the start is accepted, with `rdata_o` holding the byte sampled from `bus_i`. `done_o` is a single-cycle pulse that coincides with `ready_o` returning high.
- R9: One microsecond equals TICKS_PER_US reference clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request an operation (taken when ready) |
| op_i | input | 3 | Operation code |
| addr_i | input | 14 | Target address |
| data_i | input | 8 | Byte to program |
| ready_o | output | 1 | Idle, accepts a start |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte returned by the last read |
| addr_lo_o | output | 8 | Address bits 7:0 (P1) |
| addr_hi_o | output | 6 | Address bits 13:8 (P2.0-P2.5) |
| straps_o | output | 5 | Mode straps {P3.7,P3.6,P3.3,P2.7,P2.6} |
| bus_o | output | 8 | Data to target (P0) |
| bus_oe_o | output | 1 | Drive enable for `bus_o` |
| bus_i | input | 8 | Data from target (P0) |
| tgt_rst_o | output | 1 | Target reset pin level |
| psen_n_o | output | 1 | Target program-store-enable pin level |
| vpp_en_o | output | 1 | Programming supply enable |
| prog_n_o | output | 1 | Active-low PROG strobe |

## Verification
The bench builds the block with TICKS_PER_US=2 and shortened windows (SETUP 6, HOLD 5, READ 4 clocks; lead 2, pulse 3, gap 2, tail 3 microseconds). A 25-pulse lock write therefore takes a few hundred cycles, which leaves room for every operation code, random addresses and data, and the busy-start and illegal-code cases. A microsecond ratio above one keeps the prescaler in play: each window length is a product of the microsecond count and the ratio. The pulse counts stay at their full values of 5 and 25.

// File: rtl/eps_pkg.sv
package eps_pkg;

    typedef enum logic [2:0] {
        OP_PGM_CODE  = 3'd0,
        OP_VERIFY    = 3'd1,
        OP_PGM_CRYPT = 3'd2,
        OP_LOCK1     = 3'd3,
        OP_LOCK2     = 3'd4,
        OP_LOCK3     = 3'd5,
        OP_SIGNATURE = 3'd6,
        OP_BAD       = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_LEAD, PH_PULSE, PH_GAP, PH_TAIL, PH_HOLD, PH_READ
    } phase_e;

    function automatic logic op_is_legal(logic [2:0] code);
        return code != 3'd7;
    endfunction

    function automatic logic op_is_write(op_e o);
        return (o == OP_PGM_CODE) || (o == OP_PGM_CRYPT) ||
               (o == OP_LOCK1) || (o == OP_LOCK2) || (o == OP_LOCK3);
    endfunction

    // bit order {P3.7,P3.6,P3.3,P2.7,P2.6}
    function automatic logic [4:0] op_straps(op_e o);
        case (o)
            OP_PGM_CODE:  return 5'b11110;
            OP_VERIFY:    return 5'b11000;
            OP_PGM_CRYPT: return 5'b10110;
            OP_LOCK1:     return 5'b11111;
            OP_LOCK2:     return 5'b00111;
            OP_LOCK3:     return 5'b01101;
            default:      return 5'b00000;
        endcase
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eps_us_tick.sv
module eps_us_tick #(
    parameter int TICKS_PER_US = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICKS_PER_US - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick_o = (pre_q == PRE_TOP);

    always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/eps_seq.sv
module eps_seq
    import eps_pkg::*;
#(
    parameter int SETUP_CLKS     = 48,
    parameter int HOLD_CLKS      = 48,
    parameter int READ_CLKS      = 48,
    parameter int LEAD_US        = 10,
    parameter int PULSE_US       = 100,
    parameter int GAP_US         = 10,
    parameter int TAIL_US        = 10,
    parameter int CODE_PULSES    = 5,
    parameter int SPECIAL_PULSES = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [2:0] op_i,
    input  logic       tick_i,
    output logic       accept_o,
    output logic       clr_o,
    output logic       capture_o,
    output logic       done_o,
    output phase_e     phase_o,
    output op_e        op_o
);
    localparam int CNT_MAX = imax(imax(imax(SETUP_CLKS, HOLD_CLKS), imax(READ_CLKS, LEAD_US)),
                                  imax(imax(PULSE_US, GAP_US), TAIL_US));
    localparam int CNT_W  = $clog2(CNT_MAX + 1);
    localparam int PCNT_W = $clog2(imax(CODE_PULSES, SPECIAL_PULSES) + 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CLKS - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CLKS - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(READ_CLKS - 1);
    localparam logic [CNT_W-1:0] LD_LEAD  = CNT_W'(LEAD_US - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_US - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_US - 1);
    localparam logic [CNT_W-1:0] LD_TAIL  = CNT_W'(TAIL_US - 1);

    phase_e            phase_q, phase_d;
    op_e               op_q;
    logic [CNT_W-1:0]  cnt_q, cnt_ld;
    logic [PCNT_W-1:0] pcnt_q;
    logic              done_q, in_us, step, expire, fin;

    assign in_us  = (phase_q == PH_LEAD) || (phase_q == PH_PULSE) ||
                    (phase_q == PH_GAP)  || (phase_q == PH_TAIL);
    assign step   = in_us ? tick_i : 1'b1;
    assign expire = step && (cnt_q == '0);

    always_comb begin
        phase_d = phase_q;
        cnt_ld  = '0;
        fin     = 1'b0;
        unique case (phase_q)
            PH_IDLE:  if (start_i && op_is_legal(op_i)) begin
                          phase_d = PH_SETUP; cnt_ld = LD_SETUP;
                      end
            PH_SETUP: if (expire) begin
                          if (op_is_write(op_q)) begin phase_d = PH_LEAD; cnt_ld = LD_LEAD; end
                          else                   begin phase_d = PH_READ; cnt_ld = LD_READ; end
                      end
            PH_LEAD:  if (expire) begin phase_d = PH_PULSE; cnt_ld = LD_PULSE; end
            PH_PULSE: if (expire) begin
                          if (pcnt_q == '0) begin phase_d = PH_TAIL; cnt_ld = LD_TAIL; end
                          else              begin phase_d = PH_GAP;  cnt_ld = LD_GAP;  end
                      end
            PH_GAP:   if (expire) begin phase_d = PH_PULSE; cnt_ld = LD_PULSE; end
            PH_TAIL:  if (expire) begin phase_d = PH_HOLD;  cnt_ld = LD_HOLD;  end
            PH_HOLD:  if (expire) begin phase_d = PH_IDLE;  fin = 1'b1; end
            PH_READ:  if (expire) begin phase_d = PH_IDLE;  fin = 1'b1; end
            default:  phase_d = PH_IDLE;
        endcase
    end

    assign accept_o  = (phase_q == PH_IDLE) && (phase_d == PH_SETUP);
    assign clr_o     = (phase_d != phase_q);
    assign capture_o = (phase_q == PH_READ) && expire;
    assign done_o    = done_q;
    assign phase_o   = phase_q;
    assign op_o      = op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_PGM_CODE;
            cnt_q   <= '0;
            pcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= fin;
            if (clr_o)                         cnt_q <= cnt_ld;
            else if (step && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
            if (accept_o) begin
                op_q   <= op_e'(op_i);
                pcnt_q <= (op_e'(op_i) == OP_PGM_CODE) ? PCNT_W'(CODE_PULSES - 1)
                                                        : PCNT_W'(SPECIAL_PULSES - 1);
            end else if (phase_q == PH_PULSE && expire && pcnt_q != '0) begin
                pcnt_q <= pcnt_q - 1'b1;
            end
        end
    end

    // a PROG pulse is entered only from the supply lead-in or from a gap
    assert_pulse_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PULSE && $past(phase_q) != PH_PULSE) |->
        ($past(phase_q) == PH_LEAD || $past(phase_q) == PH_GAP));

    // the latched operation cannot change while busy
    assert_busy_op_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(op_q));
endmodule

// File: rtl/eps_pin_map.sv
module eps_pin_map
    import eps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  phase_e      phase_i,
    input  op_e         op_i,
    input  logic [13:0] addr_i,
    input  logic [7:0]  data_i,
    output logic [7:0]  addr_lo_o,
    output logic [5:0]  addr_hi_o,
    output logic [4:0]  straps_o,
    output logic [7:0]  bus_o,
    output logic        bus_oe_o,
    output logic        tgt_rst_o,
    output logic        psen_n_o,
    output logic        vpp_en_o,
    output logic        prog_n_o
);
    logic busy, wr;

    assign busy = (phase_i != PH_IDLE);
    assign wr   = busy && op_is_write(op_i);

    always_comb begin
        addr_lo_o = busy ? addr_i[7:0]  : '0;
        addr_hi_o = busy ? addr_i[13:8] : '0;
        straps_o  = busy ? op_straps(op_i) : '0;
        bus_o     = wr ? data_i : '0;
        bus_oe_o  = wr;
        tgt_rst_o = 1'b1;
        psen_n_o  = !busy;
        vpp_en_o  = wr && ((phase_i == PH_LEAD) || (phase_i == PH_PULSE) ||
                           (phase_i == PH_GAP)  || (phase_i == PH_TAIL));
        prog_n_o  = !(wr && phase_i == PH_PULSE);
    end

    assert_prog_needs_vpp_R4: assert property (@(posedge clk) disable iff (rst)
        !prog_n_o |-> vpp_en_o);

    assert_read_no_vpp_R8: assert property (@(posedge clk) disable iff (rst)
        vpp_en_o |-> bus_oe_o);
endmodule

// File: rtl/eprom_pulse_seq.sv
module eprom_pulse_seq
    import eps_pkg::*;
#(
    parameter int TICKS_PER_US   = 5,
    parameter int SETUP_CLKS     = 48,
    parameter int HOLD_CLKS      = 48,
    parameter int READ_CLKS      = 48,
    parameter int LEAD_US        = 10,
    parameter int PULSE_US       = 100,
    parameter int GAP_US         = 10,
    parameter int TAIL_US        = 10,
    parameter int CODE_PULSES    = 5,
    parameter int SPECIAL_PULSES = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  op_i,
    input  logic [13:0] addr_i,
    input  logic [7:0]  data_i,
    output logic        ready_o,
    output logic        done_o,
    output logic [7:0]  rdata_o,
    output logic [7:0]  addr_lo_o,
    output logic [5:0]  addr_hi_o,
    output logic [4:0]  straps_o,
    output logic [7:0]  bus_o,
    output logic        bus_oe_o,
    input  logic [7:0]  bus_i,
    output logic        tgt_rst_o,
    output logic        psen_n_o,
    output logic        vpp_en_o,
    output logic        prog_n_o
);
    phase_e      phase;
    op_e         op_cur;
    logic        tick, clr, accept, capture;
    logic [13:0] addr_q;
    logic [7:0]  data_q, rdata_q;

    eps_us_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk(clk), .rst(rst), .clr_i(clr), .tick_o(tick)
    );

    eps_seq #(
        .SETUP_CLKS(SETUP_CLKS), .HOLD_CLKS(HOLD_CLKS), .READ_CLKS(READ_CLKS),
        .LEAD_US(LEAD_US), .PULSE_US(PULSE_US), .GAP_US(GAP_US), .TAIL_US(TAIL_US),
        .CODE_PULSES(CODE_PULSES), .SPECIAL_PULSES(SPECIAL_PULSES)
    ) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .tick_i(tick),
        .accept_o(accept), .clr_o(clr), .capture_o(capture), .done_o(done_o),
        .phase_o(phase), .op_o(op_cur)
    );

    eps_pin_map u_pins (
        .clk(clk), .rst(rst), .phase_i(phase), .op_i(op_cur),
        .addr_i(addr_q), .data_i(data_q),
        .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o), .straps_o(straps_o),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .tgt_rst_o(tgt_rst_o),
        .psen_n_o(psen_n_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= addr_i;
                data_q <= data_i;
            end
            if (capture) rdata_q <= bus_i;
        end
    end

    assign ready_o = (phase == PH_IDLE);
    assign rdata_o = rdata_q;

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && $past(!ready_o)) |-> $stable({addr_hi_o, addr_lo_o, straps_o, bus_o}));

    assert_done_with_ready_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ready_o && $past(!ready_o)));
endmodule

// File: tb/eprom_pulse_seq_tb.sv
`timescale 1ns/100ps
module eprom_pulse_seq_tb;
    localparam int TPU = 2, SETUP = 6, HOLD = 5, READ = 4;
    localparam int LEAD = 2, PULSE = 3, GAP = 2, TAIL = 3, NCODE = 5, NSPEC = 25;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [2:0] op_in = '0;
    logic [13:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic ready_o, done_o, bus_oe_o, tgt_rst_o, psen_n_o, vpp_en_o, prog_n_o;
    logic [7:0] rdata_o, addr_lo_o, bus_o, bus_i;
    logic [5:0] addr_hi_o;
    logic [4:0] straps_o;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] tgt_byte(logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b10} ^ 8'h5C;
    endfunction

    assign bus_i = tgt_byte({addr_hi_o, addr_lo_o});

    eprom_pulse_seq #(
        .TICKS_PER_US(TPU), .SETUP_CLKS(SETUP), .HOLD_CLKS(HOLD), .READ_CLKS(READ),
        .LEAD_US(LEAD), .PULSE_US(PULSE), .GAP_US(GAP), .TAIL_US(TAIL),
        .CODE_PULSES(NCODE), .SPECIAL_PULSES(NSPEC)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op_in), .addr_i(addr_in),
        .data_i(data_in), .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
        .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o), .straps_o(straps_o),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .bus_i(bus_i), .tgt_rst_o(tgt_rst_o),
        .psen_n_o(psen_n_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_write(logic [2:0] o);
        return o == 3'd0 || o == 3'd2 || o == 3'd3 || o == 3'd4 || o == 3'd5;
    endfunction

    function automatic logic [4:0] exp_straps(logic [2:0] o);
        case (o)
            3'd0: return 5'b11110;
            3'd1: return 5'b11000;
            3'd2: return 5'b10110;
            3'd3: return 5'b11111;
            3'd4: return 5'b00111;
            3'd5: return 5'b01101;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [13:0] a, input logic [7:0] d, input bit poke);
        int k = 0, vr = -1, ff = -1, lr = -1, vf = -1, dn = -1, low_at = 0;
        int pulses = 0, bad_w = 0, bad_g = 0, pinbad = 0;
        bit pprog = 1'b1, pvpp = 1'b0, wr;
        wr = exp_write(o);
        @(negedge clk);
        start = 1'b1; op_in = o; addr_in = a; data_in = d;
        @(negedge clk);
        start = 1'b0;
        chk(ready_o == 1'b0, "R3", "ready low after start", int'(ready_o), 0);
        forever begin
            if (poke && k == 3) begin start = 1'b1; op_in = 3'd6; addr_in = ~a; data_in = ~d; end
            if (poke && k == 4) start = 1'b0;
            if (!ready_o) begin
                if ({addr_hi_o, addr_lo_o} != a || straps_o != exp_straps(o) || psen_n_o != 1'b0 ||
                    tgt_rst_o != 1'b1 || bus_oe_o != wr || (wr && bus_o != d)) pinbad++;
            end
            if (vpp_en_o && !pvpp) vr = k;
            if (!vpp_en_o && pvpp) vf = k;
            if (!prog_n_o && pprog) begin
                pulses++;
                if (ff < 0) ff = k;
                if (lr >= 0 && k - lr != GAP * TPU) bad_g++;
                low_at = k;
            end
            if (prog_n_o && !pprog) begin
                if (k - low_at != PULSE * TPU) bad_w++;
                lr = k;
            end
            if (done_o) begin dn = k; break; end
            if (k > 5000) break;
            pprog = prog_n_o; pvpp = vpp_en_o;
            @(negedge clk);
            k++;
        end
        chk(pinbad == 0, "R2", $sformatf("pin mismatch cycles op%0d", o), pinbad, 0);
        chk(dn >= 0 && ready_o == 1'b1, "R8", "ready back with done", int'(ready_o), 1);
        if (wr) begin
            chk(pulses == ((o == 3'd0) ? NCODE : NSPEC), "R5", $sformatf("pulse count op%0d", o),
                pulses, (o == 3'd0) ? NCODE : NSPEC);
            chk(bad_w == 0, "R6", "pulse width errors", bad_w, 0);
            chk(bad_g == 0, "R6", "gap width errors", bad_g, 0);
            chk(vr == SETUP, "R4", "setup before vpp", vr, SETUP);
            chk(ff - vr == LEAD * TPU, "R9", "vpp lead in clocks", ff - vr, LEAD * TPU);
            chk(vf - lr == TAIL * TPU, "R7", "vpp tail in clocks", vf - lr, TAIL * TPU);
            chk(dn - vf == HOLD, "R7", "hold after vpp off", dn - vf, HOLD);
        end else begin
            chk(vr < 0 && ff < 0, "R8", "read raised vpp or prog", pulses, 0);
            chk(dn == SETUP + READ, "R8", "read latency", dn, SETUP + READ);
            chk(rdata_o == tgt_byte(a), "R8", "read data", int'(rdata_o), int'(tgt_byte(a)));
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done single cycle", int'(done_o), 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready_o && !done_o && !vpp_en_o && prog_n_o && !bus_oe_o && psen_n_o && tgt_rst_o &&
            addr_lo_o == 0 && addr_hi_o == 0 && straps_o == 0 && bus_o == 0,
            "R1", "idle pin state", int'(straps_o), 0);

        // illegal code 7 is ignored
        @(negedge clk);
        start = 1'b1; op_in = 3'd7; addr_in = 14'h1234;
        @(negedge clk);
        start = 1'b0;
        begin
            int badc = 0;
            for (int i = 0; i < 12; i++) begin
                if (!ready_o || done_o || vpp_en_o || !psen_n_o || addr_lo_o != 0) badc++;
                @(negedge clk);
            end
            chk(badc == 0, "R3", "illegal op ignored", badc, 0);
        end

        // each operation once, extreme addresses
        run_op(3'd0, 14'h3FFF, 8'hA5, 1'b0);
        run_op(3'd1, 14'h0000, 8'h00, 1'b0);
        run_op(3'd2, 14'h003F, 8'h3C, 1'b0);
        run_op(3'd3, 14'h2AAA, 8'hFF, 1'b0);
        run_op(3'd4, 14'h1555, 8'h00, 1'b0);
        run_op(3'd5, 14'h0100, 8'h81, 1'b0);
        run_op(3'd6, 14'h0031, 8'h00, 1'b0);
        // start pulses while busy must not disturb
        run_op(3'd0, 14'h0ABC, 8'h5A, 1'b1);
        run_op(3'd1, 14'h3F00, 8'h11, 1'b1);

        for (int n = 0; n < 20; n++) begin
            run_op(3'($urandom_range(0, 6)), 14'($urandom), 8'($urandom), 1'b0);
        end

        repeat (2) @(negedge clk);
        chk(ready_o && !vpp_en_o && prog_n_o && !bus_oe_o, "R1", "idle after operations",
            int'(ready_o), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule